// File: doc/BRIEF.md
# Byte-serial status packet sender

This block turns a wide status word plus a few 32-bit side words into short packets on an 8-bit output. Each packet opens with a register address. The block raises a request while that address byte is on the output, and it waits for the receiver to acknowledge it. After the acknowledge, the remaining bytes follow on consecutive clocks, with no further handshake.

A report is made of several packets. The main status packet comes first. After it comes one packet per side word, at addresses counting up from a separate base. The whole report is built from a snapshot taken when it starts, so a status change during transmission cannot mix old and new values.

An 8-bit control write sets the mode and a 6-bit sequence number. The sequence number is carried in every main packet. The mode selects one of three behaviours:
- stay silent;
- send one report and then fall silent;
- report every time the status differs from the last value sent.

A change that arrives while a report is in progress is remembered and sent afterwards.

Top module: `status_pkt_tx`

## Requirements
- R1: While reset is high and after it, `pkt_req` is 0 and `pkt_data` is 0x00. The mode starts silent, so no report is sent until a control write enables one.
- R2: A control write takes `cfg_data[7:6]` as the mode and `cfg_data[5:0]` as the sequence number. Mode 1 sends one report and mode 2 reports on change. When mode 1 or mode 2 is written on clock edge E, `pkt_req` rises after edge E+1 with `pkt_data` = `STATUS_ADDR`.
- R3: While `pkt_req` is high without `pkt_ack`, both `pkt_req` and the address byte hold steady. The edge that samples `pkt_ack` high drops `pkt_req`. A `pkt_ack` seen while `pkt_req` is low has no effect.
- R4: After the main packet's acknowledge, the following bytes appear one per clock with `pkt_req` low. The first is {sequence[5:0], status[1:0]}. Then come status[9:2], status[17:10] and status[25:18], each next 8-bit group upward, with zero padding at the top. With no packet in progress, `pkt_data` is 0x00.
- R5: After the main packet, extra word j (j = 0 upward, in bits [32j+31:32j] of `extra_in`) is sent as its own packet. Its address is `EXTRA_BASE`+j, and after the acknowledge its four bytes follow least significant first.
- R6: In mode 1, after its one report starts the mode reverts to silent. A later status change sends nothing.
- R7: In mode 2 with the block idle, a status change that is sampled on edge E brings `pkt_req` high after edge E+2. This timing applies with the default registered status input.
- R8: In mode 2, changes during a report are latched. They yield exactly one follow-up report carrying the status held when that report starts. An unchanged status yields no further report.
- R9: Writing mode 0 or mode 3 cancels any report that has not yet started, and nothing is sent afterwards. A report already in progress still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_data | input | 8 | Control value: [7:6] mode, [5:0] sequence |
| status_in | input | STATUS_W | Parallel status word |
| extra_in | input | 32*NUM_EXTRA | Extra words, word j in bits [32j+31:32j] |
| pkt_ack | input | 1 | Acknowledge of the address byte |
| pkt_data | output | 8 | Serial packet byte |
| pkt_req | output | 1 | Packet waiting for acknowledge |

## Verification
The request after a control write is due one edge after the write edge. The request for a status change in mode 2 is due two edges after the edge that samples the change. The bench checks both at exactly those falling edges and also checks that the request is still low one negedge earlier. The scoreboard monitor plays the receiver: it reads the address at the negedge where it sees the request, and it can hold off its acknowledge for a set number of cycles. After the acknowledge it reads one data byte per following negedge, starting at the first negedge after the acknowledging edge. Cases where nothing should happen are checked by watching `pkt_req` for a dozen cycles after the stimulus.

// File: rtl/status_pkt_pkg.sv
`timescale 1ns/1ps
package status_pkt_pkg;
  localparam int SEQ_W = 6;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_ONCE   = 2'd1,
    MODE_CHANGE = 2'd2,
    MODE_MUTE   = 2'd3
  } rpt_mode_e;

  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_REQ  = 2'd1,
    SER_DATA = 2'd2
  } ser_state_e;
endpackage

// File: rtl/status_pkt_capture.sv
`timescale 1ns/1ps
module status_pkt_capture #(
  parameter int STATUS_W   = 26,
  parameter int XW         = 64,
  parameter bit REG_STATUS = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [STATUS_W-1:0] status_in,
  input  logic [XW-1:0]       extra_in,
  output logic [STATUS_W-1:0] status_q,
  output logic [XW-1:0]       extra_q
);
  generate
    if (REG_STATUS) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          status_q <= '0;
          extra_q  <= '0;
        end else begin
          status_q <= status_in;
          extra_q  <= extra_in;
        end
      end
    end else begin : g_pass
      assign status_q = status_in;
      assign extra_q  = extra_in;
    end
  endgenerate
endmodule

// File: rtl/status_pkt_ctrl.sv
`timescale 1ns/1ps
module status_pkt_ctrl
  import status_pkt_pkg::*;
#(
  parameter int STATUS_W = 26
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [7:0]          cfg_data,
  input  logic                ser_busy,
  input  logic [STATUS_W-1:0] status_q,
  input  logic [STATUS_W-1:0] status_sent,
  output logic                go,
  output logic [SEQ_W-1:0]    seq
);
  rpt_mode_e mode;
  logic      pending;
  logic      changed;
  rpt_mode_e wr_mode;

  assign wr_mode = rpt_mode_e'(cfg_data[7:6]);
  assign changed = (mode == MODE_CHANGE) && (status_q != status_sent);
  // a write in the same cycle takes precedence over starting
  assign go      = pending && !ser_busy && !cfg_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_OFF;
      seq     <= '0;
      pending <= 1'b0;
    end else if (cfg_we) begin
      mode    <= wr_mode;
      seq     <= cfg_data[SEQ_W-1:0];
      pending <= (wr_mode == MODE_ONCE) || (wr_mode == MODE_CHANGE);
    end else if (go) begin
      pending <= 1'b0;
      if (mode == MODE_ONCE) mode <= MODE_OFF;
    end else if (changed) begin
      pending <= 1'b1;
    end
  end
endmodule

// File: rtl/status_pkt_serial.sv
`timescale 1ns/1ps
module status_pkt_serial
  import status_pkt_pkg::*;
#(
  parameter int         STATUS_W    = 26,
  parameter int         NUM_EXTRA   = 2,
  parameter logic [7:0] STATUS_ADDR = 8'h3C,
  parameter logic [7:0] EXTRA_BASE  = 8'h40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go,
  input  logic [SEQ_W-1:0]       seq,
  input  logic [STATUS_W-1:0]    status_q,
  input  logic [32*NUM_EXTRA-1:0] extra_q,
  input  logic                   pkt_ack,
  output logic                   busy,
  output logic [STATUS_W-1:0]    status_sent,
  output logic [7:0]             pkt_data,
  output logic                   pkt_req
);
  localparam int NDATA    = 1 + (STATUS_W - 2 + 7) / 8;
  localparam int PW       = 2 + 8 * (NDATA - 1);
  localparam int MAIN_LEN = NDATA + 1;
  localparam int XLEN     = 5;
  localparam int MAXLEN   = (MAIN_LEN > XLEN) ? MAIN_LEN : XLEN;
  localparam int BI_W     = $clog2(MAXLEN);
  localparam int PK_W     = (NUM_EXTRA > 1) ? $clog2(NUM_EXTRA + 1) : 1;

  ser_state_e              st, st_n;
  logic [PK_W-1:0]         pk, pk_n;
  logic [BI_W-1:0]         bi, bi_n;
  logic                    req_n;
  logic [7:0]              dat_n;
  logic                    take;
  logic [STATUS_W-1:0]     snap_s;
  logic [32*NUM_EXTRA-1:0] snap_x;
  logic [SEQ_W-1:0]        snap_seq;
  logic [PW-1:0]           padded;
  logic [7:0]              nxt_byte;
  int                      nb;
  int                      last_bi;

  assign busy        = (st != SER_IDLE);
  assign status_sent = snap_s;

  // byte that follows the current one within the same packet
  always_comb begin
    nb     = int'(bi) + 1;
    padded = '0;
    padded[STATUS_W-1:0] = snap_s;
    if (pk == '0) begin
      if (nb == 1) nxt_byte = {snap_seq, snap_s[1:0]};
      else         nxt_byte = padded[2 + 8*(nb-2) +: 8];
    end else begin
      nxt_byte = snap_x[32*(int'(pk)-1) + 8*(nb-1) +: 8];
    end
  end

  always_comb begin
    st_n    = st;
    pk_n    = pk;
    bi_n    = bi;
    req_n   = pkt_req;
    dat_n   = pkt_data;
    take    = 1'b0;
    last_bi = (pk == '0) ? MAIN_LEN - 1 : XLEN - 1;
    case (st)
      SER_IDLE: if (go) begin
        st_n  = SER_REQ;
        pk_n  = '0;
        bi_n  = '0;
        req_n = 1'b1;
        dat_n = STATUS_ADDR;
        take  = 1'b1;
      end
      SER_REQ: if (pkt_ack) begin
        st_n  = SER_DATA;
        bi_n  = BI_W'(1);
        req_n = 1'b0;
        dat_n = nxt_byte;
      end
      SER_DATA: begin
        if (int'(bi) == last_bi) begin
          if (pk == PK_W'(NUM_EXTRA)) begin
            st_n  = SER_IDLE;
            dat_n = 8'h00;
          end else begin
            st_n  = SER_REQ;
            pk_n  = pk + 1'b1;
            bi_n  = '0;
            req_n = 1'b1;
            dat_n = 8'(int'(EXTRA_BASE) + int'(pk));
          end
        end else begin
          bi_n  = bi + 1'b1;
          dat_n = nxt_byte;
        end
      end
      default: st_n = SER_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SER_IDLE;
      pk       <= '0;
      bi       <= '0;
      pkt_req  <= 1'b0;
      pkt_data <= 8'h00;
      snap_s   <= '0;
      snap_x   <= '0;
      snap_seq <= '0;
    end else begin
      st       <= st_n;
      pk       <= pk_n;
      bi       <= bi_n;
      pkt_req  <= req_n;
      pkt_data <= dat_n;
      if (take) begin
        snap_s   <= status_q;
        snap_x   <= extra_q;
        snap_seq <= seq;
      end
    end
  end
endmodule

// File: rtl/status_pkt_tx.sv
`timescale 1ns/1ps
module status_pkt_tx
  import status_pkt_pkg::*;
#(
  parameter int         STATUS_W    = 26,
  parameter int         NUM_EXTRA   = 2,
  parameter bit         REG_STATUS  = 1'b1,
  parameter logic [7:0] STATUS_ADDR = 8'h3C,
  parameter logic [7:0] EXTRA_BASE  = 8'h40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [7:0]              cfg_data,
  input  logic [STATUS_W-1:0]     status_in,
  input  logic [32*NUM_EXTRA-1:0] extra_in,
  input  logic                    pkt_ack,
  output logic [7:0]              pkt_data,
  output logic                    pkt_req
);
  localparam int XW = 32 * NUM_EXTRA;

  logic [STATUS_W-1:0] status_q;
  logic [XW-1:0]       extra_q;
  logic [STATUS_W-1:0] status_sent;
  logic                ser_busy;
  logic                go;
  logic [SEQ_W-1:0]    seq;

  status_pkt_capture #(
    .STATUS_W(STATUS_W), .XW(XW), .REG_STATUS(REG_STATUS)
  ) u_capture (
    .clk(clk), .rst(rst), .status_in(status_in), .extra_in(extra_in),
    .status_q(status_q), .extra_q(extra_q)
  );

  status_pkt_ctrl #(.STATUS_W(STATUS_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .ser_busy(ser_busy), .status_q(status_q), .status_sent(status_sent),
    .go(go), .seq(seq)
  );

  status_pkt_serial #(
    .STATUS_W(STATUS_W), .NUM_EXTRA(NUM_EXTRA),
    .STATUS_ADDR(STATUS_ADDR), .EXTRA_BASE(EXTRA_BASE)
  ) u_serial (
    .clk(clk), .rst(rst), .go(go), .seq(seq), .status_q(status_q),
    .extra_q(extra_q), .pkt_ack(pkt_ack), .busy(ser_busy),
    .status_sent(status_sent), .pkt_data(pkt_data), .pkt_req(pkt_req)
  );
endmodule

// File: rtl/status_pkt_tx_chk.sv
`timescale 1ns/1ps
module status_pkt_tx_chk #(
  parameter int         NUM_EXTRA   = 2,
  parameter logic [7:0] STATUS_ADDR = 8'h3C,
  parameter logic [7:0] EXTRA_BASE  = 8'h40
) (
  input logic       clk,
  input logic       rst,
  input logic       pkt_ack,
  input logic       pkt_req,
  input logic [7:0] pkt_data,
  input logic       ser_busy
);
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      p_reset_quiet_r1: assert (!pkt_req && pkt_data == 8'h00)
        else $error("output active right after reset");
    end
  end

  p_hold_addr_r3: assert property (@(posedge clk) disable iff (rst)
    pkt_req && !pkt_ack |=> pkt_req && $stable(pkt_data));

  p_req_drop_r3: assert property (@(posedge clk) disable iff (rst)
    pkt_req && pkt_ack |=> !pkt_req);

  p_addr_valid_r5: assert property (@(posedge clk) disable iff (rst)
    pkt_req |-> (pkt_data == STATUS_ADDR) ||
                ((int'(pkt_data) >= int'(EXTRA_BASE)) &&
                 (int'(pkt_data) < int'(EXTRA_BASE) + NUM_EXTRA)));

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !ser_busy |-> pkt_data == 8'h00 && !pkt_req);
endmodule

bind status_pkt_tx status_pkt_tx_chk #(
  .NUM_EXTRA(NUM_EXTRA), .STATUS_ADDR(STATUS_ADDR), .EXTRA_BASE(EXTRA_BASE)
) u_chk (
  .clk(clk), .rst(rst), .pkt_ack(pkt_ack), .pkt_req(pkt_req),
  .pkt_data(pkt_data), .ser_busy(ser_busy)
);

// File: tb/status_pkt_tx_test.sv
`timescale 1ns/1ps
module status_pkt_tx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_data = 8'h00;
  logic [25:0] status_in = 26'h0;
  logic [63:0] extra_in = 64'hCAFE_F00D_1234_5678;
  logic        pkt_ack = 1'b0;
  logic [7:0]  pkt_data;
  logic        pkt_req;

  int checks = 0;
  int errors = 0;
  int pkts_done = 0;
  int ack_wait = 0;
  bit mon_busy = 1'b0;
  logic [7:0] exp_q[$];
  int         len_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  status_pkt_tx uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .status_in(status_in), .extra_in(extra_in), .pkt_ack(pkt_ack),
    .pkt_data(pkt_data), .pkt_req(pkt_req)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_report(logic [25:0] s, logic [5:0] sq);
    len_q.push_back(5); tag_q.push_back("R4 main packet");
    exp_q.push_back(8'h3C); exp_q.push_back({sq, s[1:0]});
    exp_q.push_back(s[9:2]); exp_q.push_back(s[17:10]);
    exp_q.push_back({6'b0, s[25:18]});
    for (int j = 0; j < 2; j++) begin
      len_q.push_back(5); tag_q.push_back("R5 extra packet");
      exp_q.push_back(8'(8'h40 + j));
      for (int b = 0; b < 4; b++) exp_q.push_back(extra_in[32*j + 8*b +: 8]);
    end
  endtask

  // scoreboard monitor acting as the receiver
  initial begin
    forever begin
      @(negedge clk);
      if (pkt_req && !rst) begin
        mon_busy = 1'b1;
        if (len_q.size() == 0) begin
          chk(1'b0, "R2 unexpected request", pkt_data, 0);
          pkt_ack = 1'b1; @(negedge clk); pkt_ack = 1'b0;
        end else begin
          int    n;
          string tg;
          logic [7:0] e;
          n = len_q.pop_front(); tg = tag_q.pop_front(); e = exp_q.pop_front();
          chk(pkt_data == e, {tg, " address"}, pkt_data, e);
          for (int w = 0; w < ack_wait; w++) begin
            @(negedge clk);
            chk(pkt_req && pkt_data == e, "R3 hold while waiting", {pkt_req, pkt_data}, {1'b1, e});
          end
          pkt_ack = 1'b1;
          @(negedge clk);
          pkt_ack = 1'b0;
          chk(!pkt_req, "R3 request dropped on acknowledge", pkt_req, 0);
          for (int k = 1; k < n; k++) begin
            if (k > 1) @(negedge clk);
            e = exp_q.pop_front();
            chk(pkt_data == e && !pkt_req, {tg, " data byte"}, {pkt_req, pkt_data}, e);
          end
          pkts_done++;
        end
        mon_busy = 1'b0;
      end
    end
  end

  task automatic wait_idle();
    int t = 0;
    while ((len_q.size() != 0 || mon_busy) && t < 5000) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
    chk(!pkt_req && pkt_data == 8'h00, "R4 idle output", {pkt_req, pkt_data}, 0);
  endtask

  task automatic quiet(int n, string tag);
    bit seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (pkt_req) seen = 1'b1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic cfg(logic [1:0] md, logic [5:0] sq);
    @(negedge clk);
    cfg_we = 1'b1; cfg_data = {md, sq};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_start(logic [1:0] md, logic [5:0] sq);
    cfg(md, sq);
    chk(!pkt_req, "R2 request not before write edge plus one", pkt_req, 0);
    @(negedge clk);
    chk(pkt_req && pkt_data == 8'h3C, "R2 request one edge after write",
        {pkt_req, pkt_data}, {1'b1, 8'h3C});
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    status_in = 26'h2A5_5A3C;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(!pkt_req && pkt_data == 8'h00, "R1 reset state", {pkt_req, pkt_data}, 0);
    quiet(10, "R1 silent after reset");

    // acknowledge with no request is ignored
    pkt_ack = 1'b1; @(negedge clk); pkt_ack = 1'b0;
    @(negedge clk);
    chk(!pkt_req && pkt_data == 8'h00, "R3 stray acknowledge ignored", {pkt_req, pkt_data}, 0);

    // single report, immediate acknowledge
    push_report(status_in, 6'h15);
    cfg_start(2'd1, 6'h15);
    wait_idle();
    chk(pkts_done == 3, "R5 packet count per report", pkts_done, 3);
    status_in = 26'h1FF_0001;
    quiet(12, "R6 once mode silent after change");

    // single report with delayed acknowledge
    ack_wait = 3;
    status_in = 26'h3C3_C3C3;
    repeat (2) @(negedge clk);
    push_report(status_in, 6'h2A);
    cfg_start(2'd1, 6'h2A);
    wait_idle();
    ack_wait = 0;

    // on-change mode
    push_report(status_in, 6'h07);
    cfg_start(2'd2, 6'h07);
    wait_idle();
    quiet(10, "R8 no report without change");
    push_report(26'h012_3456, 6'h07);
    status_in = 26'h012_3456;
    @(negedge clk); chk(!pkt_req, "R7 no request at sample edge", pkt_req, 0);
    @(negedge clk); chk(!pkt_req, "R7 no request one edge later", pkt_req, 0);
    @(negedge clk); chk(pkt_req && pkt_data == 8'h3C, "R7 request two edges after sample",
                        {pkt_req, pkt_data}, {1'b1, 8'h3C});
    wait_idle();

    // changes during a report coalesce into one follow-up
    base = pkts_done;
    push_report(26'h0AA_AAAA, 6'h07);
    status_in = 26'h0AA_AAAA;
    while (pkts_done == base) @(negedge clk);
    status_in = 26'h155_5555;
    @(negedge clk);
    status_in = 26'h3FF_0F0F;
    push_report(26'h3FF_0F0F, 6'h07);
    wait_idle();
    chk(pkts_done == base + 6, "R8 exactly one follow-up report", pkts_done, base + 6);
    quiet(10, "R8 nothing after follow-up");

    // mode 0 during a report lets it finish, then silence
    push_report(26'h000_00F3, 6'h07);
    status_in = 26'h000_00F3;
    while (!pkt_req) @(negedge clk);
    cfg(2'd0, 6'h00);
    wait_idle();
    status_in = 26'h111_1111;
    quiet(12, "R9 mode 0 silent");

    // back-to-back write cancels a pending report
    @(negedge clk);
    cfg_we = 1'b1; cfg_data = {2'd1, 6'h11};
    @(negedge clk);
    cfg_data = {2'd0, 6'h00};
    @(negedge clk);
    cfg_we = 1'b0;
    quiet(12, "R9 pending report cancelled");
    cfg(2'd3, 6'h05);
    status_in = 26'h222_2222;
    quiet(12, "R9 mode 3 silent");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule